// File: doc/BRIEF.md
# Windowed Processor Watchdog with Park-then-Reset Sequencing

This block supervises a processor through a windowed watchdog. The processor must pulse a service (kick) input while the time since the last valid kick lies inside a programmable window. The window has an opening age and a closing age, both counted in clock cycles. A kick that arrives too early is a fault. Reaching the closing age with no kick is also a fault.

On a fault the block runs an ordered recovery. It first asks the display mirror device to park. The park request stays up until the device reports that parking is done, or until a programmable number of cycles has passed. Only then does the block pulse the chipset reset, for a fixed number of cycles. Once the reset ends, supervision starts again with a fresh window.

The kind of fault is kept in a cause register, and the chipset reset does not clear it. When the chipset is out of reset, a nonzero cause drives a host interrupt line, so that initialisation software can read the cause and report it. Only a power-on reset or a host clear empties the register.

Top module: `wdog_win_supervisor`

## Requirements
- R1: While `rst` is high, on the following clock edge `park_req_o`, `chip_rst_o` and `host_irq_o` go low and `cause_o` becomes 2'b00 (no cause).
- R2: Supervision is active when neither park nor chip reset is asserted. The window age is 0 in the first active cycle and grows by one each cycle. A kick sampled while the age lies in [`win_open_i`, `win_close_i`] is valid: it raises no fault and returns the age to 0 on the next cycle.
- R3: A kick sampled during active supervision while the age is below `win_open_i` is a fault. On the next cycle `park_req_o` is high and `cause_o` is 2'b10 (early kick).
- R4: With no kick, reaching an age equal to or above `win_close_i` during active supervision is a fault. On the next cycle `park_req_o` is high and `cause_o` is 2'b01 (missed kick).
- R5: `park_req_o` stays high until a cycle in which `park_done_i` is sampled high, or a cycle in which it has already been high for `park_hold_i` earlier cycles, whichever comes first. It is low on the next cycle.
- R6: `chip_rst_o` rises exactly in the cycle after `park_req_o` falls, never overlaps it, and stays high for exactly `RST_CYC` cycles.
- R7: `cause_o` holds through the chip reset. It changes only on a fault, on `rst`, or on a cycle after `cause_clr_i` is sampled high. A fault in the same cycle as a clear wins.
- R8: `host_irq_o` is high exactly when `cause_o` is nonzero and `chip_rst_o` is low.
- R9: Kicks during park or chip reset are ignored. Supervision resumes with age 0 in the cycle after `chip_rst_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| kick_i | input | 1 | Processor service pulse |
| win_open_i | input | CNT_W | Age at which kicks become valid |
| win_close_i | input | CNT_W | Last valid age; timeout when reached with no kick |
| park_hold_i | input | CNT_W | Maximum extra cycles of park request |
| park_done_i | input | 1 | Display device reports park complete |
| cause_clr_i | input | 1 | Host clear of the cause register |
| park_req_o | output | 1 | Park request to the display device |
| chip_rst_o | output | 1 | Chipset reset pulse |
| cause_o | output | 2 | Stored reset cause: 00 none, 01 missed, 10 early |
| host_irq_o | output | 1 | Host interrupt for a logged watchdog reset |

## Verification
The bench targets kicks landing exactly on the opening and closing ages. A design with an off-by-one window bound would park on a legal kick there, or accept one cycle too many. It runs a zero opening age with a kick every cycle, and a zero park hold that must give a one-cycle park. A park-done that arrives before the hold limit must cut the park short. Other cases are kicks during park and reset, which a careless design would count or act on, and a host clear held across a fault, where the new cause must win for one cycle. A model that follows the cause through the chip reset catches a design that drops the cause during reset or raises the interrupt while reset is still asserted.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    typedef enum logic [1:0] {
        ST_WATCH    = 2'd0,
        ST_PARK     = 2'd1,
        ST_HOLD_RST = 2'd2
    } sup_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_LATE  = 2'd1,
        CAUSE_EARLY = 2'd2
    } cause_t;

    typedef struct packed {
        logic   valid;
        cause_t kind;
    } fault_t;

    function automatic logic cause_is_set(cause_t c);
        return c != CAUSE_NONE;
    endfunction

endpackage

// File: rtl/wdw_window.sv
module wdw_window
    import wdw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] open_i,
    input  logic [CNT_W-1:0] close_i,
    output fault_t           fault_o,
    output logic [CNT_W-1:0] age_o
);
    localparam logic [CNT_W-1:0] AGE_MAX = '1;

    logic [CNT_W-1:0] age_q;

    // classify the current cycle
    always_comb begin
        fault_o = '{valid: 1'b0, kind: CAUSE_NONE};
        if (active_i) begin
            if (kick_i) begin
                if (age_q < open_i) begin
                    fault_o = '{valid: 1'b1, kind: CAUSE_EARLY};
                end
            end else if (age_q >= close_i) begin
                fault_o = '{valid: 1'b1, kind: CAUSE_LATE};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active_i || kick_i || fault_o.valid) begin
            age_q <= '0;
        end else if (age_q != AGE_MAX) begin
            age_q <= age_q + 1'b1;
        end
    end

    assign age_o = age_q;

endmodule

// File: rtl/wdw_seq.sv
module wdw_seq
    import wdw_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fault_i,
    input  logic             park_done_i,
    input  logic [CNT_W-1:0] park_hold_i,
    output sup_state_t       state_o
);
    localparam int RW = $clog2(RST_CYC + 1);
    localparam int SW = (CNT_W > RW) ? CNT_W : RW;

    sup_state_t    st_q;
    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_WATCH;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                ST_WATCH: begin
                    cnt_q <= '0;
                    if (fault_i) st_q <= ST_PARK;
                end
                ST_PARK: begin
                    if (park_done_i || cnt_q >= SW'(park_hold_i)) begin
                        st_q  <= ST_HOLD_RST;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_HOLD_RST: begin
                    if (cnt_q == SW'(RST_CYC - 1)) begin
                        st_q  <= ST_WATCH;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_q  <= ST_WATCH;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign state_o = st_q;

    // observation counters for the checks below
    int unsigned park_run;
    int unsigned rst_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            park_run <= 0;
            rst_run  <= 0;
        end else begin
            park_run <= (st_q == ST_PARK) ? park_run + 1 : 0;
            rst_run  <= (st_q == ST_HOLD_RST) ? rst_run + 1 : 0;
        end
    end

    // R5
    park_len_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PARK) |-> (park_run <= 32'(park_hold_i)));

    // R6
    rst_after_park_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == ST_HOLD_RST) |-> $past(st_q == ST_PARK));

    // R6
    rst_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q == ST_HOLD_RST) |-> (rst_run == 32'(RST_CYC)));

endmodule

// File: rtl/wdw_cause.sv
module wdw_cause
    import wdw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  fault_t fault_i,
    input  logic   clr_i,
    input  logic   in_reset_i,
    output cause_t cause_o,
    output logic   irq_o
);
    cause_t cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= CAUSE_NONE;
        end else if (fault_i.valid) begin
            cause_q <= fault_i.kind;
        end else if (clr_i) begin
            cause_q <= CAUSE_NONE;
        end
    end

    assign cause_o = cause_q;
    assign irq_o   = cause_is_set(cause_q) && !in_reset_i;

    // R7
    cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fault_i.valid && !clr_i) |=> $stable(cause_q));

endmodule

// File: rtl/wdog_win_supervisor.sv
module wdog_win_supervisor
    import wdw_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] win_open_i,
    input  logic [CNT_W-1:0] win_close_i,
    input  logic [CNT_W-1:0] park_hold_i,
    input  logic             park_done_i,
    input  logic             cause_clr_i,
    output logic             park_req_o,
    output logic             chip_rst_o,
    output logic [1:0]       cause_o,
    output logic             host_irq_o
);
    sup_state_t       state_w;
    fault_t           fault_w;
    cause_t           cause_w;
    logic [CNT_W-1:0] age_w;
    logic             active_w;

    assign active_w = (state_w == ST_WATCH);

    wdw_window #(.CNT_W(CNT_W)) u_window (
        .clk      (clk),
        .rst      (rst),
        .active_i (active_w),
        .kick_i   (kick_i),
        .open_i   (win_open_i),
        .close_i  (win_close_i),
        .fault_o  (fault_w),
        .age_o    (age_w)
    );

    wdw_seq #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .fault_i     (fault_w.valid),
        .park_done_i (park_done_i),
        .park_hold_i (park_hold_i),
        .state_o     (state_w)
    );

    wdw_cause u_cause (
        .clk        (clk),
        .rst        (rst),
        .fault_i    (fault_w),
        .clr_i      (cause_clr_i),
        .in_reset_i (chip_rst_o),
        .cause_o    (cause_w),
        .irq_o      (host_irq_o)
    );

    assign park_req_o = (state_w == ST_PARK);
    assign chip_rst_o = (state_w == ST_HOLD_RST);
    assign cause_o    = cause_w;

    // R2
    valid_kick_chk: assert property (@(posedge clk) disable iff (rst)
        (active_w && kick_i && age_w >= win_open_i && age_w <= win_close_i)
        |=> !park_req_o);

    // R3
    early_kick_chk: assert property (@(posedge clk) disable iff (rst)
        (active_w && kick_i && age_w < win_open_i)
        |=> (park_req_o && cause_o == 2'b10));

    // R4
    missed_kick_chk: assert property (@(posedge clk) disable iff (rst)
        (active_w && !kick_i && age_w >= win_close_i)
        |=> (park_req_o && cause_o == 2'b01));

endmodule

// File: tb/wdog_win_supervisor_tb.sv
`timescale 1ns/1ps
module wdog_win_supervisor_tb;
    localparam int CW = 16;
    localparam int RC = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          kick, done, clr;
    logic [CW-1:0] wopen, wclose, hold;
    logic          park, crst, irq;
    logic [1:0]    cause;

    always #2.5 clk = ~clk;

    wdog_win_supervisor #(.CNT_W(CW), .RST_CYC(RC)) u_dut (
        .clk(clk), .rst(rst), .kick_i(kick), .win_open_i(wopen),
        .win_close_i(wclose), .park_hold_i(hold), .park_done_i(done),
        .cause_clr_i(clr), .park_req_o(park), .chip_rst_o(crst),
        .cause_o(cause), .host_irq_o(irq)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit cmp_on = 0;

    // behavioural model: 0 watching, 1 parking, 2 resetting
    int m_st = 0, m_age = 0, m_cnt = 0, m_cause = 0;

    always @(posedge clk) begin
        int f, k;
        cycles++;
        if (rst) begin
            m_st = 0; m_age = 0; m_cnt = 0; m_cause = 0;
        end else begin
            f = 0; k = 0;
            if (m_st == 0) begin
                if (kick) begin
                    if (m_age < int'(wopen)) begin f = 1; k = 2; end
                    else m_age = 0;
                end else if (m_age >= int'(wclose)) begin
                    f = 1; k = 1;
                end else begin
                    m_age++;
                end
            end else if (m_st == 1) begin
                if (done || m_cnt >= int'(hold)) begin m_st = 2; m_cnt = 0; end
                else m_cnt++;
            end else begin
                if (m_cnt == RC - 1) begin m_st = 0; m_cnt = 0; m_age = 0; end
                else m_cnt++;
            end
            if (f != 0) begin
                m_st = 1; m_cnt = 0; m_age = 0; m_cause = k;
            end else if (clr) begin
                m_cause = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(park == (m_st == 1), "R5 park_req", int'(park), int'(m_st == 1));
            chk(crst == (m_st == 2), "R6 chip_rst", int'(crst), int'(m_st == 2));
            chk(int'(cause) == m_cause, "R7 cause", int'(cause), m_cause);
            chk(irq == (m_cause != 0 && m_st != 2), "R8 host_irq",
                int'(irq), int'(m_cause != 0 && m_st != 2));
        end
    end

    always @(negedge clk) begin
        if (cycles > 60000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 60000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic kick_at(input int a);
        do @(negedge clk); while (!(m_st == 0 && m_age == a));
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic wait_watch();
        do @(negedge clk); while (m_st != 0);
    endtask

    initial begin
        rst = 1'b1; kick = 1'b0; done = 1'b0; clr = 1'b0;
        wopen = 16'd5; wclose = 16'd20; hold = 16'd10;
        cyc(3);
        cmp_on = 1;
        // R1 reset state
        chk(park == 0 && crst == 0, "R1 outputs low", int'(park | crst), 0);
        chk(cause == 2'b00 && irq == 0, "R1 cause empty", int'(cause), 0);
        rst = 1'b0;

        // R2 valid kicks, including both window edges
        kick_at(10); kick_at(10); kick_at(5); kick_at(20); kick_at(12);
        chk(park == 0 && cause == 2'b00, "R2 legal kicks", int'(park), 0);

        // R4 timeout: age 0 now, fault sampled at age 20
        cyc(20);
        chk(park == 0, "R4 still waiting", int'(park), 0);
        cyc(1);
        chk(park == 1 && cause == 2'b01, "R4 missed kick", int'(cause), 1);
        // R9 kicks during park and reset are ignored
        kick = 1'b1; cyc(14); kick = 1'b0;
        chk(crst == 1, "R9 reset still running", int'(crst), 1);
        wait_watch();
        chk(cause == 2'b01 && irq == 1, "R7 cause kept after reset", int'(cause), 1);

        // R7 host clear
        clr = 1'b1; cyc(1); clr = 1'b0;
        chk(cause == 2'b00 && irq == 0, "R7 host clear", int'(cause), 0);

        // R3 early kick, park cut short by done (R5)
        kick_at(2);
        chk(park == 1 && cause == 2'b10, "R3 early kick", int'(cause), 2);
        cyc(2); done = 1'b1; cyc(1); done = 1'b0;
        chk(park == 0 && crst == 1, "R5 park ended by done", int'(crst), 1);
        wait_watch();

        // R7 fault wins over a clear held high
        clr = 1'b1;
        do @(negedge clk); while (m_st != 1);
        chk(cause == 2'b01, "R7 fault beats clear", int'(cause), 1);
        cyc(1);
        chk(cause == 2'b00, "R7 clear after fault", int'(cause), 0);
        clr = 1'b0;
        wait_watch();

        // R2 zero opening age: kick every cycle is legal
        wopen = 16'd0; wclose = 16'd3;
        kick = 1'b1; cyc(12); kick = 1'b0;
        chk(park == 0, "R2 kick each cycle", int'(park), 0);

        // R5 zero hold gives a one-cycle park
        hold = 16'd0;
        do @(negedge clk); while (m_st != 1);
        chk(park == 1, "R5 one-cycle park", int'(park), 1);
        cyc(1);
        chk(park == 0 && crst == 1, "R6 reset follows park", int'(crst), 1);
        wait_watch();

        // R1 power-on reset clears a stored cause
        rst = 1'b1; cyc(1);
        chk(cause == 2'b00 && irq == 0, "R1 reset clears cause", int'(cause), 0);
        rst = 1'b0;
        cyc(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule